// File: doc/BRIEF.md
# Pointer Update Hazard Checker

This block sits after the decode stage of a small 16-bit pipelined CPU. For each valid instruction it receives a set of decoded attribute flags. It detects when that instruction depends on a pointer register that the instruction directly before it wrote. The early operand address stage of such a pipeline cannot see the new value in time, so one instruction must separate the write from the use.

Three groups of pointers are tracked:

- the context pointer, which forms register-bank addresses;
- four data page pointers, which long and indirect addressing read;
- the stack pointer, which return and pop operations read implicitly.

The block flags each hazard with a one-cycle violation pulse, a type code and the page index. The `STALL_EN` parameter selects a variant that also requests a one-cycle stall. After the stall, the held instruction is checked again as though a bubble had been inserted.

The decision is combinational: it appears in the same cycle as the offending instruction. The only state is a one-entry record of the pointers that the previous cycle's accepted instruction wrote.

Top module: `ptr_hazard_chk`

## Requirements
- R1: A valid instruction with `uses_ctx`=1, presented in the cycle directly after a valid, accepted instruction with `wr_ctx`=1, gives `viol`=1 and `viol_type`=1 in that same cycle.
- R2: A valid instruction with `use_page_en`=1 and `use_page_idx`=n, directly after an accepted instruction with `wr_page[n]`=1, gives `viol`=1, `viol_type`=2 and `viol_page`=n.
- R3: A page pointer write creates no hazard in either of two cases: the next instruction uses a different page index, or it has `use_page_en`=0.
- R4: `stk_op` encodes the class of implicit stack read:
  - 0: none
  - 1: return
  - 2: interrupt return
  - 3: inter-segment return
  - 4: return with pop
  - 5: pop
  - 6: push
  - 7: other

  Directly after an accepted `wr_stk`=1 instruction, codes 1 to 5 give `viol_type`=3, and codes 0, 6 and 7 give no hazard.
- R5: Either of the following clears every pending hazard:
  - one intervening valid instruction that writes none of the pointers;
  - one cycle with `in_valid`=0.
- R6: When several hazards occur together, the priority is context (1), then page (2), then stack (3). `viol_page` reads 0 unless `viol_type` is 2.
- R7: With `in_valid`=0, `viol`, `viol_type`, `viol_page` and `stall` are all 0.
- R8: With `STALL_EN`=1, `stall` equals `viol`. A stalled instruction does not enter the record, and the record is cleared. The same instruction presented again in the next cycle therefore gives no violation, and `stall` never stays high for two cycles.
- R9: With `STALL_EN`=0, `stall` stays 0, and every valid instruction enters the record, including one that raised a violation.
- R10: A synchronous active-high `rst` clears the record, so the first instruction after reset never reports a hazard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| wr_ctx | input | 1 | Instruction writes the context pointer |
| uses_ctx | input | 1 | Instruction forms a register-bank address from the context pointer |
| wr_page | input | NUM_PAGES | Mask of page pointers the instruction writes |
| wr_stk | input | 1 | Instruction explicitly writes the stack pointer |
| use_page_en | input | 1 | Instruction uses a page pointer through long or indirect addressing |
| use_page_idx | input | IDX_W | Index of the page pointer used |
| stk_op | input | 3 | Implicit stack-read class (R4 encoding) |
| viol | output | 1 | Hazard detected for the current instruction |
| viol_type | output | 2 | 0 none, 1 context, 2 page, 3 stack |
| viol_page | output | IDX_W | Page index when viol_type is 2, else 0 |
| stall | output | 1 | One-cycle stall request (STALL_EN variant only) |

## Verification
The bench builds two instances on one shared input stream. One uses `STALL_EN`=0 and the other `STALL_EN`=1, and both use the default `NUM_PAGES`=4. This way the flag-only record update and the clear-on-stall record update are compared cycle by cycle against separate models.

With four page pointers, random masks often write several pointers at once. The same-index and different-index cases for page use then both occur frequently. The stall instance makes it possible to re-present a held instruction and confirm that no second violation follows.

// File: rtl/ptr_hazard_pkg.sv
package ptr_hazard_pkg;

    typedef enum logic [1:0] {
        VT_NONE = 2'd0,
        VT_CTX  = 2'd1,
        VT_PAGE = 2'd2,
        VT_STK  = 2'd3
    } viol_t;

    typedef enum logic [2:0] {
        SK_NONE  = 3'd0,
        SK_RET   = 3'd1,
        SK_RETI  = 3'd2,
        SK_RETS  = 3'd3,
        SK_RETP  = 3'd4,
        SK_POP   = 3'd5,
        SK_PUSH  = 3'd6,
        SK_OTHER = 3'd7
    } stk_op_t;

    // True for the classes that read the stack pointer implicitly.
    function automatic logic stk_reads(input logic [2:0] op);
        return (op >= SK_RET) && (op <= SK_POP);
    endfunction

endpackage

// File: rtl/ptr_prev_rec.sv
module ptr_prev_rec #(
    parameter int NUM_PAGES = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 clear,
    input  logic                 wr_ctx,
    input  logic [NUM_PAGES-1:0] wr_page,
    input  logic                 wr_stk,
    output logic                 rec_ctx,
    output logic [NUM_PAGES-1:0] rec_page,
    output logic                 rec_stk
);

    typedef struct packed {
        logic                 ctx;
        logic [NUM_PAGES-1:0] page;
        logic                 stk;
    } rec_t;

    rec_t rec_d, rec_q;

    // An idle cycle or a stalled instruction leaves an empty record.
    always_comb begin
        rec_d = '0;
        if (in_valid && !clear) begin
            rec_d.ctx  = wr_ctx;
            rec_d.page = wr_page;
            rec_d.stk  = wr_stk;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_q <= '0;
        end else begin
            rec_q <= rec_d;
        end
    end

    assign rec_ctx  = rec_q.ctx;
    assign rec_page = rec_q.page;
    assign rec_stk  = rec_q.stk;

    a_r5_idle_clears : assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (rec_q == '0));

endmodule

// File: rtl/ptr_hazard_det.sv
module ptr_hazard_det #(
    parameter int NUM_PAGES = 4,
    parameter int IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic                 in_valid,
    input  logic                 uses_ctx,
    input  logic                 use_page_en,
    input  logic [IDX_W-1:0]     use_page_idx,
    input  logic [2:0]           stk_op,
    input  logic                 rec_ctx,
    input  logic [NUM_PAGES-1:0] rec_page,
    input  logic                 rec_stk,
    output logic                 hit_ctx,
    output logic                 hit_page,
    output logic                 hit_stk
);
    import ptr_hazard_pkg::*;

    logic [NUM_PAGES-1:0] page_match;

    for (genvar i = 0; i < NUM_PAGES; i++) begin : g_page
        assign page_match[i] = rec_page[i] && (use_page_idx == IDX_W'(i));
    end

    always_comb begin
        hit_ctx  = in_valid && uses_ctx && rec_ctx;
        hit_page = in_valid && use_page_en && (|page_match);
        hit_stk  = in_valid && rec_stk && stk_reads(stk_op);
    end

endmodule

// File: rtl/ptr_viol_arb.sv
module ptr_viol_arb #(
    parameter int IDX_W = 2
) (
    input  logic             hit_ctx,
    input  logic             hit_page,
    input  logic             hit_stk,
    input  logic [IDX_W-1:0] use_page_idx,
    output logic             viol,
    output logic [1:0]       viol_type,
    output logic [IDX_W-1:0] viol_page
);
    import ptr_hazard_pkg::*;

    viol_t sel;

    always_comb begin
        sel       = VT_NONE;
        viol_page = '0;
        if (hit_ctx) begin
            sel = VT_CTX;
        end else if (hit_page) begin
            sel       = VT_PAGE;
            viol_page = use_page_idx;
        end else if (hit_stk) begin
            sel = VT_STK;
        end
        viol      = (sel != VT_NONE);
        viol_type = sel;
    end

endmodule

// File: rtl/ptr_hazard_chk.sv
module ptr_hazard_chk #(
    parameter int NUM_PAGES = 4,
    parameter bit STALL_EN  = 1'b0,
    localparam int IDX_W    = $clog2(NUM_PAGES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic                 wr_ctx,
    input  logic                 uses_ctx,
    input  logic [NUM_PAGES-1:0] wr_page,
    input  logic                 wr_stk,
    input  logic                 use_page_en,
    input  logic [IDX_W-1:0]     use_page_idx,
    input  logic [2:0]           stk_op,
    output logic                 viol,
    output logic [1:0]           viol_type,
    output logic [IDX_W-1:0]     viol_page,
    output logic                 stall
);
    import ptr_hazard_pkg::*;

    logic                 rec_ctx, rec_stk;
    logic [NUM_PAGES-1:0] rec_page;
    logic                 hit_ctx, hit_page, hit_stk;

    ptr_prev_rec #(.NUM_PAGES(NUM_PAGES)) u_rec (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .clear    (stall),
        .wr_ctx   (wr_ctx),
        .wr_page  (wr_page),
        .wr_stk   (wr_stk),
        .rec_ctx  (rec_ctx),
        .rec_page (rec_page),
        .rec_stk  (rec_stk)
    );

    ptr_hazard_det #(.NUM_PAGES(NUM_PAGES), .IDX_W(IDX_W)) u_det (
        .in_valid     (in_valid),
        .uses_ctx     (uses_ctx),
        .use_page_en  (use_page_en),
        .use_page_idx (use_page_idx),
        .stk_op       (stk_op),
        .rec_ctx      (rec_ctx),
        .rec_page     (rec_page),
        .rec_stk      (rec_stk),
        .hit_ctx      (hit_ctx),
        .hit_page     (hit_page),
        .hit_stk      (hit_stk)
    );

    ptr_viol_arb #(.IDX_W(IDX_W)) u_arb (
        .hit_ctx      (hit_ctx),
        .hit_page     (hit_page),
        .hit_stk      (hit_stk),
        .use_page_idx (use_page_idx),
        .viol         (viol),
        .viol_type    (viol_type),
        .viol_page    (viol_page)
    );

    if (STALL_EN) begin : g_stall
        assign stall = viol;
    end else begin : g_flag
        assign stall = 1'b0;
    end

    a_r7_quiet_when_idle : assert property (@(posedge clk) disable iff (rst)
        !in_valid |-> (!viol && !stall));

    a_r1_ctx_needs_write : assert property (@(posedge clk) disable iff (rst)
        (viol && viol_type == VT_CTX) |-> $past(in_valid && wr_ctx && !stall));

    a_r2_page_needs_prev : assert property (@(posedge clk) disable iff (rst)
        (viol && viol_type == VT_PAGE) |-> (use_page_en && $past(in_valid && !stall && (|wr_page))));

    a_r4_stk_needs_write : assert property (@(posedge clk) disable iff (rst)
        (viol && viol_type == VT_STK) |-> ($past(in_valid && wr_stk && !stall) && stk_reads(stk_op)));

    a_r8_stall_single : assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    a_r10_first_after_reset : assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !viol);

endmodule

// File: tb/tb_ptr_hazard_chk.sv
module tb_ptr_hazard_chk;
    localparam int NP = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst, in_valid, wr_ctx, uses_ctx, wr_stk, use_page_en;
    logic [NP-1:0] wr_page;
    logic [1:0]    use_page_idx;
    logic [2:0]    stk_op;
    logic          viol0, viol1, stall0, stall1;
    logic [1:0]    vt0, vt1, vp0, vp1;

    int total = 0;
    int bad   = 0;

    logic          m_ctx [2];
    logic [NP-1:0] m_pg  [2];
    logic          m_stk [2];

    ptr_hazard_chk #(.NUM_PAGES(NP), .STALL_EN(1'b0)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wr_ctx(wr_ctx),
        .uses_ctx(uses_ctx), .wr_page(wr_page), .wr_stk(wr_stk),
        .use_page_en(use_page_en), .use_page_idx(use_page_idx),
        .stk_op(stk_op), .viol(viol0), .viol_type(vt0),
        .viol_page(vp0), .stall(stall0));

    ptr_hazard_chk #(.NUM_PAGES(NP), .STALL_EN(1'b1)) dut_stall (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wr_ctx(wr_ctx),
        .uses_ctx(uses_ctx), .wr_page(wr_page), .wr_stk(wr_stk),
        .use_page_en(use_page_en), .use_page_idx(use_page_idx),
        .stk_op(stk_op), .viol(viol1), .viol_type(vt1),
        .viol_page(vp1), .stall(stall1));

    task automatic chk(string req, string what, int got, int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
        end
    endtask

    function automatic int exp_type(int m);
        logic hc, hp, hs;
        hc = in_valid && uses_ctx && m_ctx[m];
        hp = in_valid && use_page_en && m_pg[m][use_page_idx];
        hs = in_valid && m_stk[m] && (stk_op >= 3'd1) && (stk_op <= 3'd5);
        if (hc) return 1;
        if (hp) return 2;
        if (hs) return 3;
        return 0;
    endfunction

    task automatic drive(logic v, logic wc, logic uc, logic [NP-1:0] wp, logic ws,
                         logic upe, logic [1:0] upi, logic [2:0] so);
        in_valid = v; wr_ctx = wc; uses_ctx = uc; wr_page = wp; wr_stk = ws;
        use_page_en = upe; use_page_idx = upi; stk_op = so;
    endtask

    // One cycle: check both instances mid-cycle, then advance the models.
    task automatic cyc(string none_tag);
        int et [2];
        string tag;
        @(negedge clk);
        for (int m = 0; m < 2; m++) begin
            et[m] = exp_type(m);
            tag = (et[m] == 1) ? "R1" : (et[m] == 2) ? "R2" : (et[m] == 3) ? "R4" : none_tag;
            if (!in_valid) tag = "R7";
            if (m == 0) begin
                chk(tag, "flag viol", int'(viol0), int'(et[0] != 0));
                chk(tag, "flag type", int'(vt0), et[0]);
                chk((et[0] == 2) ? tag : "R6", "flag page", int'(vp0),
                    (et[0] == 2) ? int'(use_page_idx) : 0);
                chk("R9", "flag stall", int'(stall0), 0);
            end else begin
                chk(tag, "stall viol", int'(viol1), int'(et[1] != 0));
                chk(tag, "stall type", int'(vt1), et[1]);
                chk((et[1] == 2) ? tag : "R6", "stall page", int'(vp1),
                    (et[1] == 2) ? int'(use_page_idx) : 0);
                chk("R8", "stall req", int'(stall1), int'(et[1] != 0));
            end
        end
        @(posedge clk);
        for (int m = 0; m < 2; m++) begin
            if (rst || !in_valid || (m == 1 && et[1] != 0)) begin
                m_ctx[m] = 1'b0; m_pg[m] = '0; m_stk[m] = 1'b0;
            end else begin
                m_ctx[m] = wr_ctx; m_pg[m] = wr_page; m_stk[m] = wr_stk;
            end
        end
        #1;
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd7731);
        for (int m = 0; m < 2; m++) begin
            m_ctx[m] = 1'b0; m_pg[m] = '0; m_stk[m] = 1'b0;
        end
        rst = 1'b1;
        drive(1, 1, 0, 4'hF, 1, 0, 0, 0);
        @(posedge clk); #1;
        cyc("R10"); cyc("R10");
        rst = 1'b0;
        // R10: writes presented during reset must not flag the first instruction
        drive(1, 0, 1, 4'h0, 0, 1, 2, 3'd1); cyc("R10");

        // R1: context pointer write then use
        drive(1, 1, 0, 4'h0, 0, 0, 0, 0); cyc("R5");
        drive(1, 0, 1, 4'h0, 0, 0, 0, 0); cyc("R1");
        drive(0, 0, 0, 4'h0, 0, 0, 0, 0); cyc("R7");

        // R2: same page index
        drive(1, 0, 0, 4'b0100, 0, 0, 0, 0); cyc("R5");
        drive(1, 0, 0, 4'h0, 0, 1, 2, 0); cyc("R2");
        // R3: other index, and no page use
        drive(1, 0, 0, 4'b0001, 0, 0, 0, 0); cyc("R5");
        drive(1, 0, 0, 4'h0, 0, 1, 3, 0); cyc("R3");
        drive(1, 0, 0, 4'b0001, 0, 0, 0, 0); cyc("R5");
        drive(1, 0, 0, 4'h0, 0, 0, 0, 0); cyc("R3");

        // R4: every stack class after a stack pointer write
        for (int op = 0; op < 8; op++) begin
            drive(1, 0, 0, 4'h0, 1, 0, 0, 0); cyc("R5");
            drive(1, 0, 0, 4'h0, 0, 0, 0, 3'(op)); cyc("R4");
        end

        // R5: one filler instruction, then one idle cycle, as separation
        drive(1, 1, 0, 4'hF, 1, 0, 0, 0); cyc("R5");
        drive(1, 0, 0, 4'h0, 0, 0, 0, 0); cyc("R5");
        drive(1, 0, 1, 4'h0, 0, 1, 1, 3'd5); cyc("R5");
        drive(1, 1, 0, 4'hF, 1, 0, 0, 0); cyc("R5");
        drive(0, 0, 1, 4'h0, 0, 1, 1, 3'd5); cyc("R7");
        drive(1, 0, 1, 4'h0, 0, 1, 1, 3'd5); cyc("R5");

        // R6: priority among simultaneous hazards
        drive(1, 1, 0, 4'b0010, 1, 0, 0, 0); cyc("R5");
        drive(1, 0, 1, 4'h0, 0, 1, 1, 3'd1); cyc("R6");
        drive(1, 0, 0, 4'b0010, 1, 0, 0, 0); cyc("R5");
        drive(1, 0, 0, 4'h0, 0, 1, 1, 3'd1); cyc("R6");

        // R8 / R9: hold an offending instruction for a second cycle
        drive(1, 1, 0, 4'h0, 0, 0, 0, 0); cyc("R5");
        drive(1, 1, 1, 4'h0, 0, 0, 0, 0); cyc("R8");
        cyc("R8");
        cyc("R9");

        // Random mix
        for (int n = 0; n < 4000; n++) begin
            drive(($urandom % 5) != 0, ($urandom % 3) == 0, ($urandom % 3) == 0,
                  NP'($urandom % 16) & {NP{($urandom % 2) == 0}}, ($urandom % 3) == 0,
                  ($urandom % 2) == 0, 2'($urandom % 4), 3'($urandom % 8));
            cyc("R3");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule